// File: doc/BRIEF.md
# GPIO controller with interrupt sensing

A general-purpose I/O block for up to 32 pins, reached through a simple 32-bit register bus with a setup phase and an access phase. Each pin carries an output-enable bit, an output data bit that software changes either as a whole word or atomically through separate set and clear words, and a synchronised input value that software can read back.

Every pin can also raise an interrupt. Three per-pin configuration words choose the detection kind: edge or level, single or both edges, and the active polarity. Edge events are latched until software acknowledges them with a write-one-to-clear word. Level events follow the live synchronised input. A raw status word shows pending events whatever the mask. A masked status word shows only the unmasked ones, and a single interrupt line is the OR of the masked status. A per-pin debounce enable word is stored and driven out to the pad filter, which sits outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The direction word (offset 0x00) drives `pin_oe`. A bit of 1 makes that pin an output. The word reads back as written.
- R2: Writing the set word (0x08) sets the output data bits where the written value has 1s and leaves the others unchanged. The output data word (0x10) is also directly writable, reads back, and drives `pin_out`.
- R3: Writing the clear word (0x0C) clears the output data bits where the written value has 1s and leaves the others unchanged.
- R4: The input data word (0x14) returns `pin_in` after a two-flop synchroniser. A change made just after a rising clock edge is visible in the register after the second following rising edge.
- R5: With the sense bit (0x1C) at 0 and the enable bit (0x18) at 1, a pin latches raw status bit (0x28) on an edge. Both-edges bit (0x20) = 1 catches either transition. Otherwise polarity bit (0x24) = 1 catches rising edges and 0 catches falling edges. The status is set on the third rising clock edge after the pin changes.
- R6: With the sense bit at 1 and the enable bit at 1, the raw status bit is 1 while the synchronised input equals the polarity bit (1 = active high, 0 = active low). The both-edges bit has no effect in this mode. The status appears on the second rising clock edge after the pin changes.
- R7: With the enable bit at 0, no transition and no level sets raw status for that pin.
- R8: A mask bit (0x2C) of 1 suppresses the pin. The masked status word (0x30) equals raw AND NOT mask, the raw word ignores the mask, and `irq` is 1 exactly when any masked status bit is 1.
- R9: Writing 1s to the acknowledge word (0x34) clears latched edge status for those pins. Bits written as 0 have no effect. Level status stays 1 while its condition holds, even when acknowledged.
- R10: The debounce enable word (0x38) reads back as written and drives `db_en`.
- R11: After reset every register, `pin_oe`, `pin_out`, `db_en` and `irq` are zero. Reads of 0x04, 0x08, 0x0C and any offset other than those listed return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (8) | Byte offset of the register |
| pwdata | input | NPINS (32) | Write data |
| prdata | output | NPINS (32) | Read data, valid while selected |
| pin_in | input | NPINS (32) | Pin input values, asynchronous |
| pin_out | output | NPINS (32) | Pin output data |
| pin_oe | output | NPINS (32) | Pin output enable |
| db_en | output | NPINS (32) | Per-pin debounce enable |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect on the rising edge that ends its access phase. Read data is combinational from the address and is sampled in the access phase. A pin change made just after a rising edge shows up in the input data word and in level status after two edges, and in edge status and `irq` after three edges. The bench drives pins on falling edges and samples `irq` one falling edge at a time, so it can confirm that the result is absent one edge early and present on the edge it is due. The vector loop gives the synchroniser and edge latch four edges before it reads status.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [NPINS-1:0] pwdata,
  output logic [NPINS-1:0] prdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] db_en,
  output logic             irq
);
  localparam logic [AW-1:0] OFS_DIR  = AW'('h00);
  localparam logic [AW-1:0] OFS_SET  = AW'('h08);
  localparam logic [AW-1:0] OFS_CLR  = AW'('h0C);
  localparam logic [AW-1:0] OFS_OUT  = AW'('h10);
  localparam logic [AW-1:0] OFS_IN   = AW'('h14);
  localparam logic [AW-1:0] OFS_EN   = AW'('h18);
  localparam logic [AW-1:0] OFS_SNS  = AW'('h1C);
  localparam logic [AW-1:0] OFS_ANY  = AW'('h20);
  localparam logic [AW-1:0] OFS_POL  = AW'('h24);
  localparam logic [AW-1:0] OFS_RAW  = AW'('h28);
  localparam logic [AW-1:0] OFS_MSK  = AW'('h2C);
  localparam logic [AW-1:0] OFS_MIS  = AW'('h30);
  localparam logic [AW-1:0] OFS_ACK  = AW'('h34);
  localparam logic [AW-1:0] OFS_DBN  = AW'('h38);
  localparam logic [NPINS-1:0] ZERO  = '0;

  logic [NPINS-1:0] dir_q, out_q, en_q, sns_q, any_q, pol_q, msk_q, dbn_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, edge_q;
  logic [NPINS-1:0] rise, fall, edge_hit, lvl_hit, raw, mis;
  logic             wr;

  assign wr = psel & penable & pwrite;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      en_q  <= '0;
      sns_q <= '0;
      any_q <= '0;
      pol_q <= '0;
      msk_q <= '0;
      dbn_q <= '0;
    end else if (wr) begin
      case (paddr)
        OFS_DIR: dir_q <= pwdata;
        OFS_EN:  en_q  <= pwdata;
        OFS_SNS: sns_q <= pwdata;
        OFS_ANY: any_q <= pwdata;
        OFS_POL: pol_q <= pwdata;
        OFS_MSK: msk_q <= pwdata;
        OFS_DBN: dbn_q <= pwdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       out_q <= '0;
    else if (wr && paddr == OFS_OUT)  out_q <= pwdata;
    else if (wr && paddr == OFS_SET)  out_q <= out_q | pwdata;
    else if (wr && paddr == OFS_CLR)  out_q <= out_q & ~pwdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = en_q & ~sns_q & ((any_q & (rise | fall)) |
                                     (~any_q & pol_q & rise) |
                                     (~any_q & ~pol_q & fall));
  assign lvl_hit  = en_q & sns_q & ~(sync2_q ^ pol_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                       edge_q <= '0;
    else if (wr && paddr == OFS_ACK)  edge_q <= (edge_q & ~pwdata) | edge_hit;
    else                              edge_q <= edge_q | edge_hit;
  end

  assign raw = lvl_hit | (edge_q & ~sns_q);
  assign mis = raw & ~msk_q;
  assign irq = |mis;

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign db_en   = dbn_q;

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        OFS_DIR: prdata = dir_q;
        OFS_OUT: prdata = out_q;
        OFS_IN:  prdata = sync2_q;
        OFS_EN:  prdata = en_q;
        OFS_SNS: prdata = sns_q;
        OFS_ANY: prdata = any_q;
        OFS_POL: prdata = pol_q;
        OFS_RAW: prdata = raw;
        OFS_MSK: prdata = msk_q;
        OFS_MIS: prdata = mis;
        OFS_DBN: prdata = dbn_q;
        default: prdata = '0;
      endcase
    end
  end

  a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == OFS_DIR) |=> (pin_oe == $past(pwdata)));

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == OFS_SET) |=> ((pin_out & $past(pwdata)) == $past(pwdata)));

  a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == OFS_SET) |=> ((pin_out & ~$past(pwdata)) == ($past(pin_out) & ~$past(pwdata))));

  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == OFS_CLR) |=> ((pin_out & $past(pwdata)) == ZERO));

  a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~msk_q) == ZERO) |-> !irq);

  a_r9_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && paddr == OFS_ACK) |=> ((edge_q & $past(edge_q)) == $past(edge_q)));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == ZERO && !(wr && paddr == OFS_EN)) |=> ((lvl_hit | (edge_q & ~$past(edge_q))) == ZERO));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  localparam int N = 32;
  // {sense, both, pol, start, end, expected raw}
  localparam logic [5:0] VEC [0:9] = '{
    6'b001011, 6'b001100, 6'b000101, 6'b000010, 6'b010011,
    6'b011101, 6'b101011, 6'b101100, 6'b100101, 6'b110010 };

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [N-1:0] pwdata = '0, pin_in = '0;
  logic [N-1:0] prdata, pin_out, pin_oe, db_en;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N), .AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .db_en(db_en), .irq(irq));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 pin_oe", pin_oe, '0);
    check("R11 pin_out", pin_out, '0);
    check("R11 db_en", db_en, '0);
    check("R11 irq", {31'b0, irq}, '0);
    for (int a = 0; a <= 'h3C; a += 4) begin
      rd(8'(a), d);
      check($sformatf("R11 reset read %h", a), d, '0);
    end

    // R5 R6 vector table
    for (int i = 0; i < 10; i++) begin
      int p = i * 3;
      logic [5:0] v = VEC[i];
      logic [N-1:0] bit_p = N'(1) << p;
      pin_in[p] = v[2];
      repeat (4) @(negedge clk);
      wr(8'h1C, v[5] ? bit_p : '0);
      wr(8'h20, v[4] ? bit_p : '0);
      wr(8'h24, v[3] ? bit_p : '0);
      wr(8'h34, '1);
      wr(8'h18, bit_p);
      @(negedge clk); pin_in[p] = v[1];
      repeat (4) @(negedge clk);
      rd(8'h28, d);
      check($sformatf("%s vector %0d raw", v[5] ? "R6" : "R5", i), d, v[0] ? bit_p : '0);
      check($sformatf("R8 vector %0d irq", i), {31'b0, irq}, {31'b0, v[0]});
      wr(8'h18, '0);
      wr(8'h34, '1);
    end
    pin_in = '0;
    repeat (4) @(negedge clk);
    wr(8'h34, '1);
    wr(8'h1C, '0); wr(8'h20, '0); wr(8'h24, '0);

    // R1 direction
    wr(8'h00, 32'hA5A5_0F0F);
    check("R1 pin_oe", pin_oe, 32'hA5A5_0F0F);
    rd(8'h00, d); check("R1 readback", d, 32'hA5A5_0F0F);

    // R2 set, R3 clear
    wr(8'h10, 32'h0000_00F0);
    wr(8'h08, 32'h0000_0F01);
    check("R2 set pin_out", pin_out, 32'h0000_0FF1);
    rd(8'h10, d); check("R2 out readback", d, 32'h0000_0FF1);
    rd(8'h08, d); check("R11 set word reads zero", d, '0);
    wr(8'h0C, 32'h0000_00F1);
    check("R3 clear pin_out", pin_out, 32'h0000_0F00);
    rd(8'h0C, d); check("R11 clear word reads zero", d, '0);

    // R4 input data two edges after change
    @(negedge clk); pin_in = 32'h0123_4500;
    rd(8'h14, d); check("R4 input sync", d, 32'h0123_4500);
    pin_in = '0;
    repeat (4) @(negedge clk);

    // R6 timing: level high on pin 7
    wr(8'h1C, 32'h0000_0080);
    wr(8'h24, 32'h0000_0280);
    wr(8'h18, 32'h0000_0280);
    @(negedge clk); pin_in[7] = 1;
    @(negedge clk); check("R6 level not yet after one edge", {31'b0, irq}, '0);
    @(negedge clk); check("R6 level due after two edges", {31'b0, irq}, 1);
    // R5 timing: rising edge on pin 9 (pin 7 masked)
    wr(8'h2C, 32'h0000_0080);
    check("R8 mask hides level", {31'b0, irq}, '0);
    @(negedge clk); pin_in[9] = 1;
    @(negedge clk); @(negedge clk);
    check("R5 edge not yet after two edges", {31'b0, irq}, '0);
    @(negedge clk); check("R5 edge due after three edges", {31'b0, irq}, 1);

    // R8 mask and masked status
    wr(8'h2C, 32'h0000_0280);
    check("R8 all masked irq", {31'b0, irq}, '0);
    rd(8'h28, d); check("R8 raw ignores mask", d, 32'h0000_0280);
    rd(8'h30, d); check("R8 masked status", d, '0);
    wr(8'h2C, 32'h0000_0080);
    rd(8'h30, d); check("R8 masked status partial", d, 32'h0000_0200);
    check("R8 irq unmasked", {31'b0, irq}, 1);

    // R9 acknowledge
    wr(8'h34, 32'h0000_0000);
    rd(8'h28, d); check("R9 zero write no effect", d, 32'h0000_0280);
    wr(8'h34, 32'h0000_0280);
    rd(8'h28, d); check("R9 edge cleared, level held", d, 32'h0000_0080);
    check("R9 irq after ack", {31'b0, irq}, '0);

    // R7 disabled pin ignores both edges
    wr(8'h20, 32'h0000_1000);
    @(negedge clk); pin_in[12] = 1;
    repeat (4) @(negedge clk); pin_in[12] = 0;
    repeat (4) @(negedge clk);
    rd(8'h28, d); check("R7 disabled pin no status", d, 32'h0000_0080);

    // R10 debounce enable
    wr(8'h38, 32'hDEAD_BEEF);
    rd(8'h38, d); check("R10 debounce readback", d, 32'hDEAD_BEEF);
    check("R10 db_en", db_en, 32'hDEAD_BEEF);

    // R11 unmapped offsets
    wr(8'h04, '1); wr(8'h3C, '1); wr(8'h40, '1);
    rd(8'h04, d); check("R11 0x04 zero", d, '0);
    rd(8'h3C, d); check("R11 0x3C zero", d, '0);
    rd(8'h40, d); check("R11 0x40 zero", d, '0);
    check("R11 unmapped writes leave pin_out", pin_out, 32'h0000_0F00);
    check("R11 unmapped writes leave pin_oe", pin_oe, 32'hA5A5_0F0F);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule